// File: doc/BRIEF.md
# CAN Controller Mode Manager and Register Write Guard

This block owns the operating mode of a CAN-style controller and screens every register write that software issues. Three modes exist: sleep, freeze (used for initialization) and normal. Software drives two level request inputs, one asking for sleep and one asking for freeze. The block answers each with its own acknowledge status output one clock later. A debug-halt input, qualified by a pause-enable input, forces freeze over every software request. While the block is in sleep, the gated controller clock enable is low.

Register writes arrive on a plain port made of a strobe, an address and data. Each write either passes through to the register file as a one-cycle commit, carrying the same address and data, or is dropped and signalled by a one-cycle reject pulse. Four classes of protected register each have their own gate. The bit-timing register depends on the mode. The filter mode, scale and FIFO-assignment registers depend on a filter-configuration flag. Each filter bank's data registers depend on that flag or on the bank's active bit. Each transmit mailbox depends on its empty flag. Writes to any other address always pass.

Top module: `can_mode_guard`

## Requirements
- R1: During and right after synchronous reset the block is in sleep: sleep_ack=1, freeze_ack=0, clk_en=0, mode=2'b10, and neither wr_commit nor wr_reject is high.
- R2: When sleep_req is high (and no paused debug halt is present), sleep_ack is 1 and clk_en is 0 after the next clock edge. When sleep_req is low, sleep_ack is 0 after the next clock edge.
- R3: Mode is encoded as normal=2'b00, freeze=2'b01, sleep=2'b10. Sleep takes priority over freeze_req. freeze_req alone gives freeze with freeze_ack=1. With no request the mode is normal. clk_en is 1 in every mode except sleep.
- R4: dbg_halt with pause_en high forces freeze one edge later, whatever the requests are. dbg_halt with pause_en low has no effect on the mode.
- R5: A write to address 0x00 (bit timing) is accepted only when the mode before that clock edge is freeze.
- R6: Writes to addresses 0x01 to 0x03 (filter mode, scale, FIFO assignment) are accepted only when filt_cfg=1.
- R7: Filter bank b owns addresses 0x40+2b and 0x41+2b, for b=0..13. A write there is accepted when filt_cfg=1 or bank_active[b]=0.
- R8: Mailbox m owns addresses 0x20+4m to 0x23+4m, for m=0..2. A write there is accepted only when mbox_empty[m]=1, in any mode including sleep.
- R9: Writes to any other address are always accepted.
- R10: An accepted write gives wr_commit=1 one edge later, with commit_addr and commit_data equal to the write. A blocked write gives wr_reject=1 and wr_commit=0 for one cycle. A cycle with no strobe gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Software sleep request level |
| freeze_req | input | 1 | Software freeze request level |
| dbg_halt | input | 1 | Debug halt indication |
| pause_en | input | 1 | Lets debug halt force freeze |
| sleep_ack | output | 1 | Sleep entered |
| freeze_ack | output | 1 | Freeze entered |
| mode | output | 2 | Current mode code |
| clk_en | output | 1 | Controller clock gate enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| filt_cfg | input | 1 | Filter configuration flag |
| bank_active | input | 14 | Per-bank active flags |
| mbox_empty | input | 3 | Per-mailbox empty flags |
| wr_commit | output | 1 | Accepted write pulse |
| commit_addr | output | 8 | Address of accepted write |
| commit_data | output | 32 | Data of accepted write |
| wr_reject | output | 1 | Blocked write pulse |

## Verification
Every result of this block, both the mode and acknowledge outputs and the commit or reject of a write, is due exactly one rising edge after the inputs that cause it. The bench therefore changes inputs on a falling edge and checks on the following falling edge. Its reference model advances the expected mode by one step per edge. It judges the bit-timing gate against the mode held before that edge, so that a write issued in the same cycle as a freeze request is expected to be rejected.

// File: rtl/can_mg_pkg.sv
package can_mg_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_FREEZE = 2'b01,
    MD_SLEEP  = 2'b10
  } mode_e;
endpackage

// File: rtl/can_mg_fsm.sv
module can_mg_fsm
  import can_mg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sleep_req,
  input  logic  freeze_req,
  input  logic  dbg_halt,
  input  logic  pause_en,
  output mode_e mode_q,
  output logic  sleep_ack,
  output logic  freeze_ack,
  output logic  clk_en
);
  mode_e mode_d;
  logic  forced;

  assign forced = dbg_halt && pause_en;

  // Priority: paused debug halt, then sleep, then freeze, then normal
  always_comb begin
    if (forced)          mode_d = MD_FREEZE;
    else if (sleep_req)  mode_d = MD_SLEEP;
    else if (freeze_req) mode_d = MD_FREEZE;
    else                 mode_d = MD_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MD_SLEEP;
      sleep_ack  <= 1'b1;
      freeze_ack <= 1'b0;
      clk_en     <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      sleep_ack  <= (mode_d == MD_SLEEP);
      freeze_ack <= (mode_d == MD_FREEZE);
      clk_en     <= (mode_d != MD_SLEEP);
    end
  end

  p_sleep_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !forced) |=> sleep_ack);
  p_sleep_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !sleep_req |=> !sleep_ack);
  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    forced |=> (freeze_ack && !sleep_ack));
  p_ack_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(sleep_ack && freeze_ack));
  p_clk_gate_r1: assert property (@(posedge clk) disable iff (rst)
    clk_en != sleep_ack);
endmodule

// File: rtl/can_mg_decode.sv
module can_mg_decode #(
  parameter int ADDR_W    = 8,
  parameter int NBANK     = 14,
  parameter int NMBOX     = 3,
  parameter int BTIM_ADDR = 0,
  parameter int FCFG_LO   = 1,
  parameter int FCFG_HI   = 3,
  parameter int BANK_BASE = 'h40,
  parameter int BANK_REGS = 2,
  parameter int MBOX_BASE = 'h20,
  parameter int MBOX_REGS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_btim,
  output logic              is_fcfg,
  output logic [NBANK-1:0]  bank_hit,
  output logic [NMBOX-1:0]  mbox_hit
);
  localparam logic [ADDR_W-1:0] BT_A = ADDR_W'(BTIM_ADDR);
  localparam logic [ADDR_W-1:0] FC_L = ADDR_W'(FCFG_LO);
  localparam logic [ADDR_W-1:0] FC_H = ADDR_W'(FCFG_HI);

  assign is_btim = (addr == BT_A);
  assign is_fcfg = (addr >= FC_L) && (addr <= FC_H);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BANK_BASE + BANK_REGS * b);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BANK_BASE + BANK_REGS * (b + 1));
    assign bank_hit[b] = (addr >= LO) && (addr < HI);
  end

  for (genvar m = 0; m < NMBOX; m++) begin : g_mbox
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(MBOX_BASE + MBOX_REGS * m);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(MBOX_BASE + MBOX_REGS * (m + 1));
    assign mbox_hit[m] = (addr >= LO) && (addr < HI);
  end
endmodule

// File: rtl/can_mg_gate.sv
module can_mg_gate
  import can_mg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBANK  = 14,
  parameter int NMBOX  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              is_btim,
  input  logic              is_fcfg,
  input  logic [NBANK-1:0]  bank_hit,
  input  logic [NMBOX-1:0]  mbox_hit,
  input  logic              filt_cfg,
  input  logic [NBANK-1:0]  bank_active,
  input  logic [NMBOX-1:0]  mbox_empty,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              wr_reject
);
  logic allow;

  always_comb begin
    if (is_btim)         allow = (mode_q == MD_FREEZE);
    else if (is_fcfg)    allow = filt_cfg;
    else if (|bank_hit)  allow = filt_cfg || |(bank_hit & ~bank_active);
    else if (|mbox_hit)  allow = |(mbox_hit & mbox_empty);
    else                 allow = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_commit   <= 1'b0;
      wr_reject   <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      wr_commit <= wr_en && allow;
      wr_reject <= wr_en && !allow;
      if (wr_en && allow) begin
        commit_addr <= wr_addr;
        commit_data <= wr_data;
      end
    end
  end

  p_btim_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_btim && mode_q != MD_FREEZE) |=> (wr_reject && !wr_commit));
  p_mbox_open_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && |(mbox_hit & mbox_empty)) |=> wr_commit);
  p_fcfg_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_fcfg && !filt_cfg) |=> wr_reject);
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wr_commit != wr_reject));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!wr_commit && !wr_reject));
endmodule

// File: rtl/can_mode_guard.sv
module can_mode_guard
  import can_mg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBANK  = 14,
  parameter int NMBOX  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              freeze_req,
  input  logic              dbg_halt,
  input  logic              pause_en,
  output logic              sleep_ack,
  output logic              freeze_ack,
  output logic [1:0]        mode,
  output logic              clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              filt_cfg,
  input  logic [NBANK-1:0]  bank_active,
  input  logic [NMBOX-1:0]  mbox_empty,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              wr_reject
);
  mode_e             mode_q;
  logic              is_btim, is_fcfg;
  logic [NBANK-1:0]  bank_hit;
  logic [NMBOX-1:0]  mbox_hit;

  assign mode = mode_q;

  can_mg_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .freeze_req(freeze_req),
    .dbg_halt(dbg_halt), .pause_en(pause_en), .mode_q(mode_q),
    .sleep_ack(sleep_ack), .freeze_ack(freeze_ack), .clk_en(clk_en)
  );

  can_mg_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .NMBOX(NMBOX)) u_dec (
    .addr(wr_addr), .is_btim(is_btim), .is_fcfg(is_fcfg),
    .bank_hit(bank_hit), .mbox_hit(mbox_hit)
  );

  can_mg_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .NMBOX(NMBOX)) u_gate (
    .clk(clk), .rst(rst), .mode_q(mode_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .is_btim(is_btim), .is_fcfg(is_fcfg),
    .bank_hit(bank_hit), .mbox_hit(mbox_hit), .filt_cfg(filt_cfg),
    .bank_active(bank_active), .mbox_empty(mbox_empty), .wr_commit(wr_commit),
    .commit_addr(commit_addr), .commit_data(commit_data), .wr_reject(wr_reject)
  );
endmodule

// File: tb/can_mode_guard_tb_top.sv
`timescale 1ns/1ps
module can_mode_guard_tb_top;
  localparam int CYC = 4;
  logic clk = 1'b0;
  logic rst;
  logic sleep_req, freeze_req, dbg_halt, pause_en;
  logic sleep_ack, freeze_ack, clk_en;
  logic [1:0] mode;
  logic wr_en, filt_cfg;
  logic [7:0] wr_addr, commit_addr;
  logic [31:0] wr_data, commit_data;
  logic [13:0] bank_active;
  logic [2:0] mbox_empty;
  logic wr_commit, wr_reject;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_mode;

  always #(CYC/2) clk = ~clk;

  can_mode_guard dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .freeze_req(freeze_req),
    .dbg_halt(dbg_halt), .pause_en(pause_en), .sleep_ack(sleep_ack),
    .freeze_ack(freeze_ack), .mode(mode), .clk_en(clk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .filt_cfg(filt_cfg),
    .bank_active(bank_active), .mbox_empty(mbox_empty), .wr_commit(wr_commit),
    .commit_addr(commit_addr), .commit_data(commit_data), .wr_reject(wr_reject)
  );

  function automatic logic [1:0] next_mode(logic s, logic f, logic h, logic p);
    if (h && p) return 2'b01;
    if (s)      return 2'b10;
    if (f)      return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic gate_ok(logic [7:0] a, logic [1:0] md, logic fc,
                                   logic [13:0] act, logic [2:0] emp);
    if (a == 8'h00) return md == 2'b01;
    if (a >= 8'h01 && a <= 8'h03) return fc;
    if (a >= 8'h40 && a < 8'h5C) return fc || !act[(a - 8'h40) >> 1];
    if (a >= 8'h20 && a < 8'h2C) return emp[(a - 8'h20) >> 2];
    return 1'b1;
  endfunction

  function automatic string region_tag(logic [7:0] a);
    if (a == 8'h00) return "R5";
    if (a >= 8'h01 && a <= 8'h03) return "R6";
    if (a >= 8'h40 && a < 8'h5C) return "R7";
    if (a >= 8'h20 && a < 8'h2C) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Apply the current inputs across one rising edge and check all results
  task automatic cycle();
    logic [1:0] nm;
    logic ok;
    string mtag, wtag;
    nm = next_mode(sleep_req, freeze_req, dbg_halt, pause_en);
    ok = gate_ok(wr_addr, m_mode, filt_cfg, bank_active, mbox_empty);
    mtag = dbg_halt ? "R4" : (sleep_req ? "R2" : "R3");
    wtag = wr_en ? region_tag(wr_addr) : "R10";
    @(posedge clk);
    @(negedge clk);
    m_mode = nm;
    check(mtag, {60'd0, sleep_ack, freeze_ack, clk_en, 1'b0} | {62'd0, mode},
          {60'd0, nm == 2'b10, nm == 2'b01, nm != 2'b10, 1'b0} | {62'd0, nm});
    check(wtag, {62'd0, wr_commit, wr_reject},
          {62'd0, wr_en && ok, wr_en && !ok});
    if (wr_en && ok)
      check("R10", {24'd0, commit_addr, commit_data}, {24'd0, wr_addr, wr_data});
  endtask

  task automatic do_write(logic [7:0] a);
    wr_en = 1'b1; wr_addr = a; wr_data = $urandom;
    cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    #(CYC * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst = 1'b1; sleep_req = 1'b1; freeze_req = 1'b0; dbg_halt = 1'b0; pause_en = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; filt_cfg = 1'b0;
    bank_active = '0; mbox_empty = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {58'd0, sleep_ack, freeze_ack, clk_en, mode, wr_commit | wr_reject},
          {58'd0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0});
    rst = 1'b0; m_mode = 2'b10;

    // R8 mailbox writable in sleep when empty, blocked when full
    mbox_empty = 3'b010; do_write(8'h25); do_write(8'h21); do_write(8'h2B);
    // R5 bit timing blocked in sleep
    do_write(8'h00);
    // R3 freeze request; write in same cycle still blocked (R5)
    sleep_req = 1'b0; freeze_req = 1'b1; do_write(8'h00);
    do_write(8'h00);
    // R3 normal mode, R5 blocked again
    freeze_req = 1'b0; cycle(); do_write(8'h00);
    // R4 halt without pause ignored, then with pause forced freeze
    dbg_halt = 1'b1; cycle(); pause_en = 1'b1; cycle(); sleep_req = 1'b1; cycle();
    dbg_halt = 1'b0; cycle(); sleep_req = 1'b0; cycle();
    // R6, R7 and R9 boundaries
    filt_cfg = 1'b0; bank_active = 14'h2001;
    do_write(8'h03); do_write(8'h40); do_write(8'h5B); do_write(8'h42); do_write(8'h5C);
    filt_cfg = 1'b1; do_write(8'h01); do_write(8'h41); do_write(8'h04);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 == 0) sleep_req = ~sleep_req;
      if ($urandom % 8 == 0) freeze_req = ~freeze_req;
      if ($urandom % 16 == 0) dbg_halt = ~dbg_halt;
      if ($urandom % 32 == 0) pause_en = ~pause_en;
      filt_cfg = $urandom;
      bank_active = $urandom;
      mbox_empty = $urandom;
      wr_en = ($urandom % 4) != 0;
      wr_data = $urandom;
      case ($urandom % 6)
        0: wr_addr = 8'h00;
        1: wr_addr = 8'h01 + 8'($urandom % 3);
        2: wr_addr = 8'h40 + 8'($urandom % 28);
        3: wr_addr = 8'h20 + 8'($urandom % 12);
        4: wr_addr = 8'($urandom);
        default: wr_addr = ($urandom % 2) ? 8'h5C : 8'h2C;
      endcase
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule